// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

This block is a watchdog counter that escalates through four timeout stages in a fixed order. Each stage has its own programmable length in clock cycles and its own programmable expiry action. While the watchdog is enabled and no feed strobe arrives, it counts through stage 0. When a stage's length has elapsed, it performs that stage's action and moves on to the next stage. After stage 3 expires, it applies that stage's action and then waits, idle, until it is fed or disabled.

A stage's action can be one of the following: nothing, a level interrupt, a core reset request, a main-system reset request, or a full reset request that also covers the always-on domain. The full reset may only come from an instance built for the always-on domain. The block only issues requests. The reset logic that acts on them lives elsewhere.

Software, or whatever watches the system, feeds the watchdog with a one-cycle strobe. The strobe clears the counter, returns the watchdog to stage 0 and drops the interrupt. Deasserting the enable input does the same and also silences every output.

Top module: `wdt_multistage`

## Requirements
- R1: Stages run in the order 0, 1, 2, 3. Let B_s be the total of the effective lengths of stages 0..s. Stage s expires on the B_s-th consecutive enabled, unfed rising edge, counted after the last restart.
- R2: A stage length of 0 behaves exactly like a length of 1 cycle.
- R3: The action field is 3 bits per stage, with stage s at bits [3s+2:3s]. The codes are 0 = none, 1 = interrupt, 2 = core reset, 3 = system reset, 4 = full reset. Codes 5, 6 and 7 behave as none.
- R4: Code 4 drives `full_rst_o` only when `ALWAYS_ON` is 1. In any other instance, code 4 has no effect.
- R5: Each reset request output is high for exactly the one cycle that follows the expiring edge.
- R6: `irq_o` rises in the cycle after an interrupt-stage expiry. It stays high until a feed or a disable.
- R7: A feed clears the counter, returns the watchdog to stage 0 and clears `irq_o`. On the edge where a feed and an expiry coincide, the feed wins and the expiry does not happen.
- R8: After stage 3 expires, no further request is issued until a feed or a disable.
- R9: While `enable_i` is low, all outputs are low in the next cycle and the stage returns to 0. Counting restarts from stage 0 when `enable_i` is reasserted.
- R10: While `rst_ni` is low, all outputs are low.
- R11: At most one of the three reset request outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Watchdog runs while high |
| feed_i | input | 1 | Feed strobe; restarts from stage 0 |
| stage_tmo_i | input | 4*CNT_W | Per-stage length in cycles; stage s at [s*CNT_W +: CNT_W] |
| stage_act_i | input | 12 | Per-stage action code; stage s at [3s +: 3] |
| irq_o | output | 1 | Interrupt request level |
| core_rst_o | output | 1 | Core reset request pulse |
| sys_rst_o | output | 1 | Main-system reset request pulse |
| full_rst_o | output | 1 | System plus always-on reset request pulse |

## Verification
The bench sweeps every action code over all stages and every stage length of a 3-bit counter, including zero. This catches a zero length that either wraps to a full-range count or expires without taking a cycle, and off-by-one stage boundaries that shift every later request. It places a feed on every cycle of a run, including the exact expiry edges. A design that lets the expiry win there fires a spurious request. A design that forgets to reset the stage resumes mid-chain.

Two instances run side by side, one with and one without the always-on setting, so a full reset leaking out of the main-domain instance shows up at once. Long idle tails after stage 3 expose a counter that wraps back to stage 0. Disable/re-enable runs expose a counter that keeps counting while disabled.

// File: rtl/wdt_ms_pkg.sv
// Shared definitions for the four-stage watchdog: action codes, the decoded
// request bundle and the decode function. Assumes a 3-bit action code.
package wdt_ms_pkg;

    localparam int unsigned NUM_STAGES = 4;
    localparam int unsigned ACT_W      = 3;
    localparam int unsigned STG_W      = $clog2(NUM_STAGES);

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE = 3'd0,
        ACT_IRQ  = 3'd1,
        ACT_CORE = 3'd2,
        ACT_SYS  = 3'd3,
        ACT_FULL = 3'd4
    } act_code_e;

    typedef struct packed {
        logic irq;
        logic core;
        logic sys;
        logic full;
    } act_req_t;

    // Turn a raw action code into request bits; unknown codes and a full
    // reset in a main-domain instance both yield no request.
    function automatic act_req_t decode_act(logic [ACT_W-1:0] code, bit aon);
        act_req_t r;
        r = '0;
        case (code)
            ACT_IRQ:  r.irq  = 1'b1;
            ACT_CORE: r.core = 1'b1;
            ACT_SYS:  r.sys  = 1'b1;
            ACT_FULL: r.full = aon;
            default:  r      = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wdt_ms_stage_timer.sv
// Stage sequencer and cycle counter. Counts enabled, unfed edges within the
// active stage. It flags expiry on the edge that completes the stage length,
// then advances, or goes idle after the last stage.
// Assumes: a length of 0 means 1 cycle; feed and disable both restart.
module wdt_ms_stage_timer
    import wdt_ms_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        en_i,
    input  logic                        feed_i,
    input  logic [NUM_STAGES*CNT_W-1:0] tmo_i,
    output logic [STG_W-1:0]            stage_o,
    output logic                        idle_o,
    output logic                        expire_o
);

    localparam logic [STG_W-1:0] LAST_STAGE = STG_W'(NUM_STAGES - 1);

    logic [CNT_W-1:0] tmo_arr [NUM_STAGES];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cur_tmo;
    logic [CNT_W-1:0] terminal;
    logic [STG_W-1:0] stage_q;
    logic             idle_q;

    // Slice the flat length vector into one entry per stage.
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_slice
        assign tmo_arr[s] = tmo_i[s*CNT_W +: CNT_W];
    end

    // Pick the active stage's length and its last counter value.
    always_comb begin
        cur_tmo  = tmo_arr[stage_q];
        terminal = (cur_tmo == '0) ? '0 : cur_tmo - CNT_W'(1);
    end

    // Expiry: the counter reaches the last cycle of the stage while running.
    assign expire_o = en_i && !feed_i && !idle_q && (cnt_q == terminal);

    // Advance the counter, stage and idle flag; feed and disable restart.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i || feed_i) begin
            cnt_q   <= '0;
            stage_q <= '0;
            idle_q  <= 1'b0;
        end else if (expire_o) begin
            cnt_q <= '0;
            if (stage_q == LAST_STAGE) begin
                idle_q <= 1'b1;
            end else begin
                stage_q <= stage_q + STG_W'(1);
            end
        end else if (!idle_q) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign stage_o = stage_q;
    assign idle_o  = idle_q;

endmodule

// File: rtl/wdt_ms_action_map.sv
// Action stage: decodes each stage's action code and registers the requests
// for the stage that expires. Reset requests are one-cycle pulses. The
// interrupt is a level held until a feed or a disable.
// Assumes: at most one stage expires per cycle.
module wdt_ms_action_map
    import wdt_ms_pkg::*;
#(
    parameter bit ALWAYS_ON = 1'b0
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        en_i,
    input  logic                        feed_i,
    input  logic                        expire_i,
    input  logic [STG_W-1:0]            stage_i,
    input  logic [NUM_STAGES*ACT_W-1:0] act_i,
    output logic                        irq_o,
    output logic                        core_rst_o,
    output logic                        sys_rst_o,
    output logic                        full_rst_o
);

    act_req_t req_arr [NUM_STAGES];
    act_req_t sel;

    // Decode every stage's code once; the instance domain gates code 4.
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_dec
        assign req_arr[s] = decode_act(act_i[s*ACT_W +: ACT_W], ALWAYS_ON);
    end

    // Select the request bundle of the active stage.
    assign sel = req_arr[stage_i];

    // Register pulses and the held interrupt level.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i || feed_i) begin
            irq_o      <= 1'b0;
            core_rst_o <= 1'b0;
            sys_rst_o  <= 1'b0;
            full_rst_o <= 1'b0;
        end else begin
            irq_o      <= irq_o || (expire_i && sel.irq);
            core_rst_o <= expire_i && sel.core;
            sys_rst_o  <= expire_i && sel.sys;
            full_rst_o <= expire_i && sel.full;
        end
    end

endmodule

// File: rtl/wdt_multistage.sv
// Top of the four-stage watchdog. Joins the stage sequencer to the action
// map. Requests come out one cycle after the expiring edge.
// Assumes: synchronous active-low reset; the configuration inputs are held
// stable while enable_i is high.
module wdt_multistage
    import wdt_ms_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter bit          ALWAYS_ON = 1'b0
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        enable_i,
    input  logic                        feed_i,
    input  logic [4*CNT_W-1:0]          stage_tmo_i,
    input  logic [11:0]                 stage_act_i,
    output logic                        irq_o,
    output logic                        core_rst_o,
    output logic                        sys_rst_o,
    output logic                        full_rst_o
);

    logic [STG_W-1:0] stage;
    logic             idle;
    logic             expire;

    wdt_ms_stage_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (enable_i),
        .feed_i   (feed_i),
        .tmo_i    (stage_tmo_i),
        .stage_o  (stage),
        .idle_o   (idle),
        .expire_o (expire)
    );

    wdt_ms_action_map #(
        .ALWAYS_ON (ALWAYS_ON)
    ) u_act (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (enable_i),
        .feed_i     (feed_i),
        .expire_i   (expire),
        .stage_i    (stage),
        .act_i      (stage_act_i),
        .irq_o      (irq_o),
        .core_rst_o (core_rst_o),
        .sys_rst_o  (sys_rst_o),
        .full_rst_o (full_rst_o)
    );

endmodule

// File: rtl/wdt_multistage_chk.sv
// Property checker for wdt_multistage, attached by bind. It observes ports
// plus the sequencer's stage and idle state.
module wdt_multistage_chk #(
    parameter bit ALWAYS_ON = 1'b0
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       enable_i,
    input logic       feed_i,
    input logic [1:0] stage,
    input logic       idle,
    input logic       irq_o,
    input logic       core_rst_o,
    input logic       sys_rst_o,
    input logic       full_rst_o
);

    AST_RST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({core_rst_o, sys_rst_o, full_rst_o}) <= 1); // R11

    AST_FULL_AON_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        full_rst_o |-> (ALWAYS_ON != 1'b0)); // R4

    AST_DISABLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !(irq_o || core_rst_o || sys_rst_o || full_rst_o)); // R9

    AST_FEED_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        feed_i |=> !(irq_o || core_rst_o || sys_rst_o || full_rst_o) && stage == 2'd0); // R7

    AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && enable_i && !feed_i) |=> irq_o); // R6

    AST_STAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stage != $past(stage)) |-> (stage == 2'd0 || stage == $past(stage) + 2'd1)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idle && enable_i && !feed_i) |=> !(core_rst_o || sys_rst_o || full_rst_o)); // R8

endmodule

bind wdt_multistage wdt_multistage_chk #(
    .ALWAYS_ON (ALWAYS_ON)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .feed_i     (feed_i),
    .stage      (stage),
    .idle       (idle),
    .irq_o      (irq_o),
    .core_rst_o (core_rst_o),
    .sys_rst_o  (sys_rst_o),
    .full_rst_o (full_rst_o)
);

// File: tb/sim_wdt_multistage.sv
// Bench: sweeps codes, lengths and feed positions on a 3-bit counter, with a
// main-domain instance (u0) and an always-on instance (u1) side by side.
module sim_wdt_multistage;

    localparam int W = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           enable;
    logic           feed;
    logic [4*W-1:0] tmo_v;
    logic [11:0]    act_v;
    logic           irq0, core0, sys0, full0;
    logic           irq1, core1, sys1, full1;

    int errors = 0;
    int checks = 0;
    int n      = 0;
    int tmo [4];
    int act [4];
    string tag = "R10";

    always #4 clk = ~clk;   // 125 MHz

    wdt_multistage #(.CNT_W(W), .ALWAYS_ON(1'b0)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .feed_i(feed),
        .stage_tmo_i(tmo_v), .stage_act_i(act_v),
        .irq_o(irq0), .core_rst_o(core0), .sys_rst_o(sys0), .full_rst_o(full0));

    wdt_multistage #(.CNT_W(W), .ALWAYS_ON(1'b1)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .feed_i(feed),
        .stage_tmo_i(tmo_v), .stage_act_i(act_v),
        .irq_o(irq1), .core_rst_o(core1), .sys_rst_o(sys1), .full_rst_o(full1));

    function automatic int eff(int t);
        return (t == 0) ? 1 : t;
    endfunction

    // Expected {irq, core, sys, full} from the edge count since restart.
    function automatic logic [3:0] expv(bit aon);
        logic [3:0] r = 4'b0;
        int b = 0;
        for (int s = 0; s < 4; s++) begin
            b += eff(tmo[s]);
            if (n == b) begin
                if (act[s] == 2) r[2] = 1'b1;
                if (act[s] == 3) r[1] = 1'b1;
                if (act[s] == 4 && aon) r[0] = 1'b1;
            end
            if (b <= n && act[s] == 1) r[3] = 1'b1;
        end
        return r;
    endfunction

    function automatic int total_len();
        return eff(tmo[0]) + eff(tmo[1]) + eff(tmo[2]) + eff(tmo[3]);
    endfunction

    task automatic chk(bit ok, string t, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s n=%0d actual=%b expected=%b", t, n, got, exp);
        end
    endtask

    task automatic compare();
        logic [3:0] g0 = {irq0, core0, sys0, full0};
        logic [3:0] g1 = {irq1, core1, sys1, full1};
        logic [3:0] e0 = expv(1'b0);
        logic [3:0] e1 = expv(1'b1);
        chk(g0 == e0, {tag, " main-domain"}, g0, e0);
        chk(g1 == e1, {tag, " always-on"}, g1, e1);
        chk($countones(g1[2:0]) <= 1, "R11 exclusive", g1, e1);
    endtask

    // Drive at the falling edge, model the rising edge, sample at the next fall.
    task automatic step(bit en, bit fd);
        enable = en;
        feed   = fd;
        @(posedge clk);
        if (!en || fd) n = 0; else n++;
        @(negedge clk);
        compare();
    endtask

    task automatic cfg(int t0, int t1, int t2, int t3, int a0, int a1, int a2, int a3);
        tmo = '{t0, t1, t2, t3};
        act = '{a0, a1, a2, a3};
        for (int s = 0; s < 4; s++) begin
            tmo_v[s*W +: W] = W'(tmo[s]);
            act_v[s*3 +: 3] = 3'(act[s]);
        end
    endtask

    // Enabled run past the last stage plus an idle tail, then one disable.
    task automatic run(int tail);
        int len = total_len() + tail;
        for (int i = 0; i < len; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        rst_n  = 1'b0;
        enable = 1'b0;
        feed   = 1'b0;
        cfg(1, 1, 1, 1, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R10: outputs low during reset
        tag = "R10";
        compare();
        rst_n = 1'b1;
        enable = 1'b1;
        repeat (2) @(negedge clk);
        compare();
        enable = 1'b0;
        @(negedge clk);
        n = 0;

        // R3: every code on every stage; R4 via the two instances
        for (int c = 0; c < 8; c++) begin
            tag = "R3 R4";
            cfg(1, 2, 3, 0, c, c, c, c);
            run(6);
        end

        // R1 R2 R5 R6 R8: every stage length including zero
        for (int t = 0; t < 8; t++) begin
            tag = "R1 R2 R5 R6 R8";
            cfg(t, (t + 3) % 8, 7 - t, t, 1, 2, 3, 4);
            run(8);
            cfg(t, t, t, t, 4, 3, 2, 1);
            run(8);
        end

        // R7: a feed on every cycle position, including the expiry edges
        for (int f = 0; f < 12; f++) begin
            tag = "R7";
            cfg(2, 1, 3, 2, 1, 3, 2, 4);
            for (int i = 0; i < f; i++) step(1'b1, 1'b0);
            step(1'b1, 1'b1);
            for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
            step(1'b0, 1'b0);
        end

        // R9: disable mid-chain, idle while disabled, then restart at stage 0
        for (int d = 1; d < 7; d++) begin
            tag = "R9";
            cfg(2, 2, 2, 0, 1, 2, 3, 4);
            for (int i = 0; i < d; i++) step(1'b1, 1'b0);
            for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
            run(4);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule